// File: doc/BRIEF.md
# PWM Rising-Edge Dead-Band Delay

This block holds off the rising edge of each raw PWM channel by a programmable number of clock ticks while letting the falling edge through at once. It is the rising-edge half of a dead-band generator. A pulse that is too short for the programmed hold-off is swallowed whole, so the output never shows a sliver of high time. Several channels sit side by side. Each channel has its own raw input and its own 12-bit delay setting, and one shared enable switches the whole bank between delayed operation and a plain pass-through.

All pins are plain level signals that are sampled on the rising clock edge. There is no handshake, because a PWM level has no back-pressure: every cycle's sample is consumed. The output of every channel comes from a register. The delay setting is read only at the moment a rising edge of the input is detected, so software may rewrite it at any time without disturbing a pulse that is already in flight.

Top module: `pwm_rise_delay_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `pwm_dly` is 0 after that edge and any pending hold-off is discarded.
- R2: With `dead_en` low, `pwm_dly[i]` after edge t equals `pwm_raw[i]` sampled at edge t, whatever the delay setting.
- R3: With `dead_en` high and channel delay D in 1..4095, if `pwm_raw[i]` is first sampled high at edge k (low at edge k-1), then `pwm_dly[i]` goes high after edge k+D, provided the input stays high through edge k+D.
- R4: A delay of 0 makes `pwm_dly[i]` go high right after edge k, with the same one-clock registered latency as pass-through.
- R5: With `dead_en` high, `pwm_raw[i]` sampled low at an edge drives `pwm_dly[i]` low after that same edge and cancels any hold-off in progress.
- R6: A high input pulse of L samples with D >= L produces no high output at all; with D < L it produces exactly L-D high cycles.
- R7: The delay of channel i is captured at the detected rising edge; a new value written during a pulse acts only from the next rising edge.
- R8: Channel i uses only `pwm_raw[i]` and the field `rise_dly[i*12 +: 12]`; channels do not affect one another.
- R9: A hold-off starts only when a low sample is followed by a high sample. The sample before reset release counts as low. If `dead_en` is raised while the input is already high, the output keeps its level until the input falls.
- R10: The largest delay of 4095 is honoured: a 4100-sample pulse gives 5 high cycles and a 4095-sample pulse gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dead_en | input | 1 | 1 applies the rising-edge hold-off, 0 passes inputs through |
| rise_dly | input | NCH*12 | Per-channel hold-off in clock ticks, channel i in bits i*12 +: 12 |
| pwm_raw | input | NCH | Raw PWM level of each channel |
| pwm_dly | output | NCH | Delayed PWM level of each channel |

## Verification
Every result is due a fixed number of edges after the input sample that causes it. Pass-through, a falling input and a zero delay all show after the same edge that sampled the input. A delayed rise shows after edge k+D, where k is the first high sample. The bench drives inputs on the falling clock edge, advances its behavioural model on the rising edge from those same stable inputs, and compares every channel on the next falling edge, so each comparison sees exactly the edge count the requirements state. Pulse-level checks count output high cycles over a window that runs two samples past the input's fall, and compare the count with max(0, L-D).

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int unsigned PRD_DLY_W = 12;

  typedef enum logic [1:0] {
    PRD_LOW  = 2'd0,
    PRD_WAIT = 2'd1,
    PRD_HIGH = 2'd2
  } prd_state_e;
endpackage

// File: rtl/prd_edge_sense.sv
// Remembers the previous input sample; flags a low-to-high step.
module prd_edge_sense (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic in_q;

  always_ff @(posedge clk) begin
    if (rst) in_q <= 1'b0;
    else     in_q <= din;
  end

  assign rise = din & ~in_q;
endmodule

// File: rtl/prd_hold_timer.sv
// Down-counter for the hold-off; expire marks the final tick.
module prd_hold_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)            cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire = run && (cnt_q == W'(1));
endmodule

// File: rtl/prd_channel.sv
// One channel: edge sense, hold-off timer and output state.
module prd_channel
  import prd_pkg::*;
#(
  parameter int unsigned W = PRD_DLY_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  input  logic [W-1:0] dly,
  output logic         dout
);
  prd_state_e state_q, state_d;
  logic rise, expire;
  logic t_clear, t_load, t_run;

  prd_edge_sense u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .rise (rise)
  );

  prd_hold_timer #(.W(W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (t_clear),
    .load     (t_load),
    .load_val (dly),
    .run      (t_run),
    .expire   (expire)
  );

  always_comb begin
    state_d = state_q;
    t_clear = 1'b0;
    t_load  = 1'b0;
    t_run   = 1'b0;
    if (!en) begin
      state_d = din ? PRD_HIGH : PRD_LOW;
      t_clear = 1'b1;
    end else if (!din) begin
      state_d = PRD_LOW;
      t_clear = 1'b1;
    end else if (rise) begin
      if (dly == '0) begin
        state_d = PRD_HIGH;
      end else begin
        state_d = PRD_WAIT;
        t_load  = 1'b1;
      end
    end else if (state_q == PRD_WAIT) begin
      t_run = 1'b1;
      if (expire) state_d = PRD_HIGH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PRD_LOW;
    else     state_q <= state_d;
  end

  assign dout = (state_q == PRD_HIGH);
endmodule

// File: rtl/pwm_rise_delay_bank.sv
// Bank of independent rising-edge hold-off channels.
module pwm_rise_delay_bank #(
  parameter int unsigned NCH   = 3,
  parameter int unsigned DLY_W = prd_pkg::PRD_DLY_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dead_en,
  input  logic [NCH*DLY_W-1:0] rise_dly,
  input  logic [NCH-1:0]       pwm_raw,
  output logic [NCH-1:0]       pwm_dly
);
  localparam int unsigned TOT_W = NCH * DLY_W;

  logic [TOT_W-1:0] dly_bus;
  assign dly_bus = rise_dly;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    prd_channel #(.W(DLY_W)) u_ch (
      .clk  (clk),
      .rst  (rst),
      .en   (dead_en),
      .din  (pwm_raw[g]),
      .dly  (dly_bus[g*DLY_W +: DLY_W]),
      .dout (pwm_dly[g])
    );
  end
endmodule

// File: rtl/prd_checker.sv
module prd_checker #(
  parameter int unsigned NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           dead_en,
  input logic [NCH-1:0] pwm_raw,
  input logic [NCH-1:0] pwm_dly
);
  // R1: reset clears every output
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (pwm_dly == '0));

  // R2: pass-through when disabled
  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    !dead_en |=> (pwm_dly == $past(pwm_raw)));

  // R5: enabled output never high when the input was sampled low
  a_r5_fall_same_edge: assert property (@(posedge clk) disable iff (rst)
    dead_en |=> ((pwm_dly & ~$past(pwm_raw)) == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R3: an output rise needs a high input sample at that edge
    a_r3_rise_needs_high: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_dly[g]) |-> $past(pwm_raw[g]));
  end
endmodule

bind pwm_rise_delay_bank prd_checker #(.NCH(NCH)) u_prd_chk (
  .clk     (clk),
  .rst     (rst),
  .dead_en (dead_en),
  .pwm_raw (pwm_raw),
  .pwm_dly (pwm_dly)
);

// File: tb/sim_pwm_rise_delay_bank.sv
module sim_pwm_rise_delay_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int DW  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dead_en = 1'b0;
  logic [NCH*DW-1:0] rise_dly = '0;
  logic [NCH-1:0] pwm_raw = '0;
  logic [NCH-1:0] pwm_dly;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit live = 1'b0;
  bit done = 1'b0;

  int m_prev[NCH];
  int m_out[NCH];
  int m_act[NCH];
  int m_run[NCH];
  int m_snap[NCH];

  pwm_rise_delay_bank #(.NCH(NCH), .DLY_W(DW)) u0 (
    .clk(clk), .rst(rst), .dead_en(dead_en),
    .rise_dly(rise_dly), .pwm_raw(pwm_raw), .pwm_dly(pwm_dly)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int got, int exp, string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Behavioural reference, advanced on each rising edge.
  always @(posedge clk) begin
    live = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      int din;
      int d;
      din = int'(pwm_raw[c]);
      d = int'(rise_dly[c*DW +: DW]);
      if (rst) begin
        m_out[c] = 0; m_act[c] = 0; m_prev[c] = 0;
      end else if (!dead_en) begin
        m_out[c] = din; m_act[c] = 0;
      end else if (din == 0) begin
        m_out[c] = 0; m_act[c] = 0;
      end else if (m_prev[c] == 0) begin
        m_snap[c] = d; m_run[c] = 0;
        if (d == 0) m_out[c] = 1;
        else m_act[c] = 1;
      end else if (m_act[c] != 0) begin
        m_run[c]++;
        if (m_run[c] == m_snap[c]) begin
          m_out[c] = 1; m_act[c] = 0;
        end
      end
      if (!rst) m_prev[c] = din;
    end
  end

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (live && !done)
      for (int c = 0; c < NCH; c++)
        check(cur_req, int'(pwm_dly[c]), m_out[c], $sformatf("ch%0d level", c));
  end

  task automatic set_dly(int c, int v);
    rise_dly[c*DW +: DW] = DW'(v);
  endtask

  // Drive an L-sample pulse on channel c and count output high cycles.
  task automatic pulse(int c, int len, int exp, string req, int new_d);
    int cnt;
    cnt = 0;
    cur_req = req;
    pwm_raw[c] = 1'b1;
    for (int i = 0; i < len + 2; i++) begin
      @(negedge clk);
      if (pwm_dly[c]) cnt++;
      if (i == 0 && new_d >= 0) set_dly(c, new_d);
      if (i == len - 1) pwm_raw[c] = 1'b0;
    end
    check(req, cnt, exp, $sformatf("ch%0d high cycles, pulse %0d", c, len));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt0, cnt1, cnt2;
    repeat (3) @(negedge clk);
    check("R1", int'(pwm_dly), 0, "outputs in reset");
    rst = 1'b0;

    // R2: pass-through ignores the delay
    for (int c = 0; c < NCH; c++) set_dly(c, 7);
    pulse(0, 5, 5, "R2", -1);
    pulse(1, 1, 1, "R2", -1);

    // R3 / R4: delayed and zero-delay rises
    @(negedge clk); dead_en = 1'b1;
    set_dly(0, 3); pulse(0, 10, 7, "R3", -1);
    set_dly(2, 5); pulse(2, 6, 1, "R3", -1);
    set_dly(1, 0); pulse(1, 4, 4, "R4", -1);

    // R6: short pulses swallowed
    set_dly(0, 3);
    pulse(0, 3, 0, "R6", -1);
    pulse(0, 2, 0, "R6", -1);
    pulse(0, 4, 1, "R6", -1);
    // R5: fall cancels a running hold-off, next pulse is timed afresh
    pulse(0, 2, 0, "R5", -1);
    pulse(0, 5, 2, "R5", -1);

    // R7: mid-pulse rewrite only affects the next rise
    set_dly(0, 2);
    pulse(0, 10, 8, "R7", 6);
    pulse(0, 10, 4, "R7", -1);

    // R8: all channels at once with different delays
    cur_req = "R8";
    set_dly(0, 1); set_dly(1, 4); set_dly(2, 0);
    cnt0 = 0; cnt1 = 0; cnt2 = 0;
    pwm_raw = '1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (pwm_dly[0]) cnt0++;
      if (pwm_dly[1]) cnt1++;
      if (pwm_dly[2]) cnt2++;
      if (i == 5) pwm_raw = '0;
    end
    check("R8", cnt0, 5, "ch0 high cycles");
    check("R8", cnt1, 2, "ch1 high cycles");
    check("R8", cnt2, 6, "ch2 high cycles");

    // R9: enabling while the input is high holds the level
    cur_req = "R9";
    dead_en = 1'b0; pwm_raw[1] = 1'b1;
    repeat (2) @(negedge clk);
    dead_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", int'(pwm_dly[1]), 1, "ch1 held after enable");
    pwm_raw[1] = 1'b0;
    @(negedge clk);
    check("R5", int'(pwm_dly[1]), 0, "ch1 low after fall");

    // R9: input already high at reset release counts as a rise
    rst = 1'b1; pwm_raw[2] = 1'b1; set_dly(2, 2);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cnt2 = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (pwm_dly[2]) cnt2++;
    end
    check("R9", cnt2, 3, "ch2 high cycles after reset release");
    pwm_raw[2] = 1'b0;
    repeat (2) @(negedge clk);

    // R10: largest delay
    set_dly(2, 4095);
    pulse(2, 4100, 5, "R10", -1);
    pulse(2, 4095, 0, "R10", -1);

    // R1: reset during a hold-off
    set_dly(0, 5); pwm_raw[0] = 1'b1; cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", int'(pwm_dly), 0, "outputs after mid-run reset");
    pwm_raw = '0; rst = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule